// File: doc/BRIEF.md
# Dual-Channel High/Low Count Pulse-Width Modulator

This block drives two independent pulse-width modulated outputs from one input clock. Software describes each waveform with two tick counts, one for the high stretch and one for the low stretch, packed into a single 32-bit duty word per channel. A third word, shared by both channels, carries a run enable, a clock gate and a 7-bit prescaler for each channel. It also stores a clock-source code and a delta-sigma enable per channel. The block keeps those last two fields for readback only. A prescaler value N makes one waveform tick last N+1 input clocks.

Each period starts with the high stretch and ends with the low stretch. A duty word or prescaler written while a channel runs takes effect only at the next period boundary, so a write never produces a truncated pulse. Registers are reached through a simple write-strobe bus with byte addresses and combinational read data. Word slots 3 to 7 are reserved: writes to them are dropped and reads return zero.

Top module: `hilo_pwm_top`

## Requirements
- R1: The word index is the byte address divided by 4. Index 0 is the channel A duty word, index 1 the channel B duty word and index 2 the control word. All three reset to zero and read back the last value written. An access whose byte address has nonzero bits 1:0 writes nothing and reads zero.
- R2: In a duty word the high-time tick count sits in bits 31:16 and the low-time tick count in bits 15:0.
- R3: Control word fields: bit 0 is the A run enable and bit 1 the B run enable. Bits 2 and 3 are the A and B delta-sigma enables. Bits 5:4 are the A clock select and bits 7:6 the B clock select. Bits 14:8 are the A prescaler and bit 15 the A clock gate. Bits 22:16 are the B prescaler and bit 23 the B clock gate. Bits 31:24 read as zero.
- R4: Two clock edges after the write that starts a channel, its output goes high. Each period is high for high×(N+1) clocks and then low for low×(N+1) clocks.
- R5: A prescaler value N stretches every tick to N+1 input clocks. N=0 means no division.
- R6: A channel's output toggles only while both its run enable and its clock gate are 1. Otherwise the output is low from the second edge after the write on, and the channel's counters restart.
- R7: A high count of 0 holds the output low, whether or not the low count is zero.
- R8: A low count of 0 with a nonzero high count holds the output high.
- R9: A duty word or prescaler changed during a period takes effect only when the current period has ended.
- R10: The two channels are independent. Rewriting the control word with B's fields unchanged, or writing A's duty word, leaves B's register contents and waveform unchanged.
- R11: Writes to indices 3 to 7 change no register and no output, and reads from those indices return zero.
- R12: The clock-select and delta-sigma bits are stored and read back but do not change the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock for registers and counters |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Byte address (word index in bits 4:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data of the addressed register |
| pwmOut | output | 2 | Channel outputs, bit 0 is channel A, bit 1 is channel B |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a running period. The proof that it was deferred is a full-length old pulse followed by a new-length one. The stimulus waits for a rising edge on the output and writes the new duty word on the very next cycle. It then measures the rest of the high stretch, the old low stretch and the next full period. Constant-output cases are run over windows longer than any period they could hide, and channel B is watched while A's fields are rewritten.

// File: rtl/hilo_pwm_pkg.sv
package hilo_pwm_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int DIV_W    = 7;
  localparam int NUM_CH   = 2;
  localparam int CTRL_W   = 24;
  localparam int CTRL_IDX = NUM_CH;
  // control word field positions
  localparam int EN_LSB    = 0;
  localparam int DIV_LSB   = 8;
  localparam int CH_STRIDE = 8;

  // per-channel settings handed from the register file to a datapath
  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] divN;
    logic [CNT_W-1:0] highTicks;
    logic [CNT_W-1:0] lowTicks;
  } chanCtl_t;
endpackage

// File: rtl/hilo_pwm_regs.sv
module hilo_pwm_regs
  import hilo_pwm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output chanCtl_t          chCtl [NUM_CH]
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic [DATA_W-1:0] dutyReg [NUM_CH];
  logic [CTRL_W-1:0] ctrlReg;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) dutyReg[c] <= '0;
      ctrlReg <= '0;
    end else if (wrEn && aligned) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx == IDX_W'(c)) dutyReg[c] <= wdata;
      end
      if (idx == IDX_W'(CTRL_IDX)) ctrlReg <= wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx == IDX_W'(c)) rdata = dutyReg[c];
      end
      if (idx == IDX_W'(CTRL_IDX)) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrlReg};
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctl
    localparam int DIV_POS  = DIV_LSB + c * CH_STRIDE;
    localparam int GATE_POS = DIV_POS + DIV_W;
    assign chCtl[c].run       = ctrlReg[EN_LSB + c] & ctrlReg[GATE_POS];
    assign chCtl[c].divN      = ctrlReg[DIV_POS +: DIV_W];
    assign chCtl[c].highTicks = dutyReg[c][DATA_W-1 -: CNT_W];
    assign chCtl[c].lowTicks  = dutyReg[c][CNT_W-1:0];
  end

  // R11: writes to reserved slots leave every register as it was
  assert_unused_idx_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx > IDX_W'(CTRL_IDX)) |=>
      ($stable(ctrlReg) && $stable(dutyReg[0]) && $stable(dutyReg[1])));

  // R3: upper byte of the control word always reads zero
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (idx == IDX_W'(CTRL_IDX)) |-> (rdata[DATA_W-1:CTRL_W] == '0));
endmodule

// File: rtl/hilo_pwm_chan.sv
module hilo_pwm_chan
  import hilo_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCtl_t cfg,
  output logic     pwmOut
);
  logic             started;
  logic             phaseHigh;
  logic [DIV_W-1:0] preCnt;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] actHigh;
  logic [CNT_W-1:0] actLow;
  logic [DIV_W-1:0] actDiv;

  logic             tick;
  logic [CNT_W:0]   tickNext;
  logic             endHigh;
  logic             endLow;
  logic             boundary;

  assign tick     = (preCnt == actDiv);
  assign tickNext = {1'b0, tickCnt} + 1'b1;
  assign endHigh  = (tickNext >= {1'b0, actHigh});
  assign endLow   = (tickNext >= {1'b0, actLow});
  // period ends on the last tick of the high phase when there is no low
  // phase, or on the last tick of the low phase
  assign boundary = tick && (phaseHigh ? (endHigh && actLow == '0) : endLow);
  assign pwmOut   = phaseHigh;

  always_ff @(posedge clk) begin
    if (!rstN || !cfg.run) begin
      started   <= 1'b0;
      phaseHigh <= 1'b0;
      preCnt    <= '0;
      tickCnt   <= '0;
      actHigh   <= '0;
      actLow    <= '0;
      actDiv    <= '0;
    end else if (!started || boundary) begin
      started   <= 1'b1;
      actHigh   <= cfg.highTicks;
      actLow    <= cfg.lowTicks;
      actDiv    <= cfg.divN;
      phaseHigh <= (cfg.highTicks != '0);
      preCnt    <= '0;
      tickCnt   <= '0;
    end else if (tick) begin
      preCnt <= '0;
      if (phaseHigh && endHigh) begin
        phaseHigh <= 1'b0;
        tickCnt   <= '0;
      end else begin
        tickCnt <= tickNext[CNT_W-1:0];
      end
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // R6: a channel that is not running drives low on the next edge
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run |=> !pwmOut);

  // R7: the output is never high with a zero high count latched
  assert_zero_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    pwmOut |-> (actHigh != '0));

  // R5: the prescale counter never passes the latched divisor
  assert_prescale_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= actDiv);

  // R4: high phase tick position stays inside the high count
  assert_high_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    phaseHigh |-> (tickCnt < actHigh));

  // R9: latched settings change only at a period boundary or a restart
  assert_hold_cfg_R9: assert property (@(posedge clk) disable iff (!rstN)
    (started && cfg.run && !tick) |=>
      ($stable(actHigh) && $stable(actLow) && $stable(actDiv)));
endmodule

// File: rtl/hilo_pwm_top.sv
module hilo_pwm_top
  import hilo_pwm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCtl_t chCtl [NUM_CH];

  hilo_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .chCtl (chCtl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    hilo_pwm_chan u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .cfg    (chCtl[c]),
      .pwmOut (pwmOut[c])
    );
  end
endmodule

// File: tb/hilo_pwm_tb_top.sv
`timescale 1ns/1ps
module hilo_pwm_tb_top;
  localparam int WATCHDOG = 150000;
  localparam int LIMIT    = 4000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  pwmOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hilo_pwm_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwmOut(pwmOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic wr(input int idx, input logic [31:0] d);
    wrEn = 1'b1; addr = 5'(idx * 4); wdata = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    addr = 5'(idx * 4);
    #1;
    d = rdata;
  endtask

  task automatic runLen(input int ch, input logic lvl, output int n);
    n = 0;
    while (pwmOut[ch] === lvl && n < LIMIT) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitRise(input int ch, input string tag);
    logic prev = pwmOut[ch];
    int   k = 0;
    while (k < LIMIT) begin
      @(negedge clk);
      if (prev === 1'b0 && pwmOut[ch] === 1'b1) break;
      prev = pwmOut[ch];
      k++;
    end
    if (k >= LIMIT) check({tag, " no rising edge"}, 0, 1);
  endtask

  task automatic checkConst(input int ch, input logic lvl, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut[ch] !== lvl) bad++;
      @(negedge clk);
    end
    check(tag, bad, 0);
  endtask

  task automatic measure(input int ch, input int expHi, input int expLo, input string tag);
    int n;
    waitRise(ch, tag);
    runLen(ch, 1'b1, n);
    check({tag, " high clocks"}, n, expHi);
    runLen(ch, 1'b0, n);
    check({tag, " low clocks"}, n, expLo);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      rd(i, d);
      check("R1 reset value", d, 0);
    end
    check("R6 outputs low after reset", pwmOut, 2'b00);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(0, 32'h0003_0005);
    rd(0, d);
    check("R1 R2 duty A readback", d, 32'h0003_0005);
    addr = 5'd1; #1;
    check("R1 misaligned read zero", rdata, 0);
    wrEn = 1'b1; wdata = 32'hFFFF_FFFF; @(posedge clk); @(negedge clk); wrEn = 1'b0;
    rd(0, d);
    check("R1 misaligned write dropped", d, 32'h0003_0005);
    wr(2, 32'h0000_8001);
    check("R4 low before start", pwmOut[0], 1'b0);
    @(negedge clk);
    check("R4 high first", pwmOut[0], 1'b1);
    measure(0, 3, 5, "R4 R2 period N=0");
  endtask

  task automatic t_prescale();
    wr(2, 0);
    wr(0, 32'h0002_0004);
    wr(2, 32'h0000_8201);
    measure(0, 6, 12, "R5 prescale N=2");
  endtask

  task automatic t_gating();
    wr(2, 0);
    wr(0, 32'h0003_0005);
    wr(2, 32'h0000_0001);
    checkConst(0, 1'b0, 40, "R6 run only stays low");
    wr(2, 32'h0000_8000);
    checkConst(0, 1'b0, 40, "R6 gate only stays low");
    wr(2, 32'h0000_8001);
    waitRise(0, "R6 restart");
    wr(2, 32'h0000_8000);
    @(negedge clk);
    checkConst(0, 1'b0, 30, "R6 disable mid pulse");
  endtask

  task automatic t_zero();
    wr(2, 0);
    wr(0, 32'h0000_0004);
    wr(2, 32'h0000_8001);
    checkConst(0, 1'b0, 40, "R7 zero high count");
    wr(2, 0);
    wr(0, 32'h0000_0000);
    wr(2, 32'h0000_8001);
    checkConst(0, 1'b0, 40, "R7 both counts zero");
    wr(2, 0);
    wr(0, 32'h0005_0000);
    wr(2, 32'h0000_8101);
    @(negedge clk);
    checkConst(0, 1'b1, 60, "R8 zero low count");
  endtask

  task automatic t_update();
    int n;
    wr(2, 0);
    wr(0, 32'h000A_000A);
    wr(2, 32'h0000_8001);
    waitRise(0, "R9 sync");
    wr(0, 32'h0004_0002);
    runLen(0, 1'b1, n);
    check("R9 current high kept", n + 1, 10);
    runLen(0, 1'b0, n);
    check("R9 current low kept", n, 10);
    runLen(0, 1'b1, n);
    check("R9 new high next period", n, 4);
    runLen(0, 1'b0, n);
    check("R9 new low next period", n, 2);
  endtask

  task automatic t_indep();
    logic [31:0] d;
    wr(2, 0);
    wr(0, 32'h0003_0005);
    wr(1, 32'h0001_0001);
    wr(2, 32'h0081_8003);
    measure(1, 2, 2, "R10 B period");
    wr(2, 32'h0081_8303);
    measure(1, 2, 2, "R10 B after A prescale rewrite");
    measure(0, 12, 20, "R10 A new prescale");
    wr(0, 32'h0007_0007);
    rd(1, d);
    check("R10 B duty unchanged", d, 32'h0001_0001);
    measure(1, 2, 2, "R10 B after A duty write");
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(2, 0);
    wr(0, 32'h0003_0005);
    wr(2, 32'h0000_80FD);
    rd(2, d);
    check("R12 select bits read back", d, 32'h0000_80FD);
    measure(0, 3, 5, "R12 waveform unchanged");
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(2, 32'hFFFF_FFFF);
    rd(2, d);
    check("R3 control fields and upper byte", d, 32'h00FF_FFFF);
    wr(2, 0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    wr(0, 32'h1111_2222);
    wr(1, 32'h3333_4444);
    wr(2, 0);
    for (int i = 3; i < 8; i++) wr(i, 32'hFFFF_FFFF);
    rd(0, d); check("R11 duty A kept", d, 32'h1111_2222);
    rd(1, d); check("R11 duty B kept", d, 32'h3333_4444);
    rd(2, d); check("R11 control kept", d, 0);
    for (int i = 3; i < 8; i++) begin
      rd(i, d);
      check("R11 unused reads zero", d, 0);
    end
    checkConst(0, 1'b0, 20, "R11 output A unaffected");
    checkConst(1, 1'b0, 20, "R11 output B unaffected");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_gating();
    t_zero();
    t_update();
    t_indep();
    t_select();
    t_reserved();
    t_unused();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule